// File: doc/BRIEF.md
# CPU Processing-State Controller

This block is the sequencer that decides which of five processing states a small CPU core occupies: held in reset, running an exception entry, executing instructions, halted with the bus handed to another master, or stopped for power saving. It watches the reset pin, a watchdog overflow pulse, exception requests with their vector numbers, external bus requests, a SLEEP-executed pulse, a hardware-standby level and a wake-up interrupt. It drives the current state code, the global interrupt mask, the vector-fetch address and strobe, the bus grant, the CPU halt enable and the branch-target load.

The reset pin clears the block at once, with no clock needed. Leaving reset waits for a low-to-high edge that has been passed through a two-stage synchronizer. Exception entry is transient: a two-cycle vector read at address vector*4, a one-cycle branch load, then instruction execution. The two halt states have separate causes and separate exits. A bus hand-over ends when the other master withdraws its request. A stop entered by SLEEP ends on an unmasked interrupt. A stop entered by hardware standby ends only through reset.

Top module: `proc_state_ctrl`

## Requirements
- R1: `state_o` always carries one of five codes: RESET=0, EXCEPT=1, EXEC=2, BUSREL=3, STOP=4.
- R2: While `rst_pin_n` is low the state is RESET, entered immediately (asynchronously) from any state, with `bus_grant`, `vec_stb` and `br_load` low.
- R3: In RESET, `int_mask` and `cpu_halt` are 1. In EXCEPT, `int_mask` is 1. In all other states `int_mask` follows `ccr_imask`.
- R4: After `rst_pin_n` rises, the state stays RESET for two clock edges and becomes EXCEPT on the third, with vector number 0.
- R5: A `wdt_ovf` pulse moves any state to RESET on the next edge. The edge after the pulse ends starts EXCEPT with vector number 0.
- R6: In EXEC, `exc_req` moves to EXCEPT on the next edge and captures `exc_vec` as the vector number.
- R7: EXCEPT lasts three cycles. `vec_stb` is high for the first two with `vec_addr` = vector number * 4. `br_load` is high in the third. The next state is EXEC.
- R8: In EXEC, `bus_req` with `insn_bnd` high moves to BUSREL, where `bus_grant` and `cpu_halt` are 1. BUSREL returns to EXEC on the edge after `bus_req` falls.
- R9: `bus_req` has no effect in EXEC without `insn_bnd`, and no effect at any time during EXCEPT: `bus_grant` stays 0.
- R10: In EXEC, `sleep_exec` or `hw_standby` moves to STOP, where `cpu_halt` is 1 and `bus_grant` is 0.
- R11: A STOP entered by SLEEP leaves for EXCEPT when `irq_wake` is high and `ccr_imask` is 0, using `exc_vec` as the vector number. A masked wake has no effect.
- R12: A STOP entered by hardware standby, or one during which `hw_standby` rises, ignores `irq_wake` and is left only through reset.
- R13: The priority in EXEC, from highest to lowest, is `hw_standby`, `exc_req`, `sleep_exec`, then a bus request at a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous assert |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| exc_req | input | 1 | Exception request (trace, interrupt, trap) |
| exc_vec | input | VEC_W | Vector number for an exception or a wake-up |
| bus_req | input | 1 | Bus request from another master |
| insn_bnd | input | 1 | High at an instruction boundary |
| sleep_exec | input | 1 | Pulse: SLEEP instruction executed |
| hw_standby | input | 1 | Hardware standby request level |
| irq_wake | input | 1 | Wake-up interrupt |
| ccr_imask | input | 1 | Interrupt-mask bit from the CPU status register |
| state_o | output | 3 | Current state code |
| int_mask | output | 1 | Global interrupt mask |
| vec_addr | output | VEC_W+2 | Vector-table read address |
| vec_stb | output | 1 | Vector-table read strobe |
| bus_grant | output | 1 | Bus granted to the other master |
| cpu_halt | output | 1 | CPU halt enable |
| br_load | output | 1 | Load branch target from fetched vector |

## Verification
On every cycle, the assertions check several properties. The state code must be legal. RESET must come with mask and halt. The bus grant must never coincide with a vector strobe or with a running CPU. A strobe must last two cycles. A branch load must lead to EXEC. A watchdog pulse must lead to RESET. Only the bench's scenarios can show the parts that depend on history and ordering: the three-edge latency of the synchronized reset exit, the captured vector address, the EXEC priority order, and the different exits of a SLEEP stop and a standby stop.

// File: rtl/pst_pkg.sv
package pst_pkg;
    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_EXCEPT = 3'd1,
        ST_EXEC   = 3'd2,
        ST_BUSREL = 3'd3,
        ST_STOP   = 3'd4
    } pst_state_t;
endpackage

// File: rtl/pst_rst_sync.sv
// Two-stage synchronizer for the reset pin plus rising-edge detection
module pst_rst_sync (
    input  logic clk,
    input  logic pin_n,
    output logic rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= 1'b1;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
endmodule

// File: rtl/pst_vec_seq.sv
// Vector-fetch phase sequencer: strobe phases, then one branch-load phase
module pst_vec_seq #(
    parameter int VEC_W   = 8,
    parameter int STB_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_exc,
    input  logic             start,
    input  logic [VEC_W-1:0] start_vec,
    output logic             stb,
    output logic             load,
    output logic [VEC_W+1:0] addr
);
    localparam int PH_W = $clog2(STB_CYC + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(STB_CYC);

    logic [PH_W-1:0]  ph;
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= '0;
            vec_q <= '0;
        end else begin
            if (start) vec_q <= start_vec;
            if (!in_exc || ph == PH_LAST) ph <= '0;
            else                          ph <= ph + 1'b1;
        end
    end

    assign stb  = in_exc && (ph < PH_LAST);
    assign load = in_exc && (ph == PH_LAST);
    assign addr = {vec_q, 2'b00};
endmodule

// File: rtl/proc_state_ctrl.sv
module proc_state_ctrl #(
    parameter int VEC_W   = 8,
    parameter int STB_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_pin_n,
    input  logic             wdt_ovf,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic             bus_req,
    input  logic             insn_bnd,
    input  logic             sleep_exec,
    input  logic             hw_standby,
    input  logic             irq_wake,
    input  logic             ccr_imask,
    output logic [2:0]       state_o,
    output logic             int_mask,
    output logic [VEC_W+1:0] vec_addr,
    output logic             vec_stb,
    output logic             bus_grant,
    output logic             cpu_halt,
    output logic             br_load
);
    import pst_pkg::*;

    pst_state_t       state, nxt;
    logic             rst_rise;
    logic             wdt_pend;
    logic             stop_hw;
    logic             seq_start;
    logic [VEC_W-1:0] seq_vec;

    pst_rst_sync u_sync (
        .clk   (clk),
        .pin_n (rst_pin_n),
        .rise  (rst_rise)
    );

    assign seq_start = (state != ST_EXCEPT) && (nxt == ST_EXCEPT);
    assign seq_vec   = (state == ST_RESET) ? '0 : exc_vec;

    pst_vec_seq #(
        .VEC_W   (VEC_W),
        .STB_CYC (STB_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_pin_n),
        .in_exc    (state == ST_EXCEPT),
        .start     (seq_start),
        .start_vec (seq_vec),
        .stb       (vec_stb),
        .load      (br_load),
        .addr      (vec_addr)
    );

    // next-state selection
    always_comb begin
        nxt = state;
        if (wdt_ovf) begin
            nxt = ST_RESET;
        end else begin
            unique case (state)
                ST_RESET:  if (rst_rise || wdt_pend) nxt = ST_EXCEPT;
                ST_EXCEPT: if (br_load) nxt = ST_EXEC;
                ST_EXEC: begin
                    if (hw_standby)                nxt = ST_STOP;
                    else if (exc_req)              nxt = ST_EXCEPT;
                    else if (sleep_exec)           nxt = ST_STOP;
                    else if (bus_req && insn_bnd)  nxt = ST_BUSREL;
                end
                ST_BUSREL: if (!bus_req) nxt = ST_EXEC;
                ST_STOP:   if (!stop_hw && !hw_standby && irq_wake && !ccr_imask)
                               nxt = ST_EXCEPT;
                default:   nxt = ST_RESET;
            endcase
        end
    end

    // state register with its side records
    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            state    <= ST_RESET;
            wdt_pend <= 1'b0;
            stop_hw  <= 1'b0;
        end else begin
            state <= nxt;
            if (wdt_ovf)                                 wdt_pend <= 1'b1;
            else if (state == ST_RESET && nxt != ST_RESET) wdt_pend <= 1'b0;
            if (state != ST_STOP && nxt == ST_STOP)      stop_hw <= hw_standby;
            else if (state == ST_STOP && hw_standby)     stop_hw <= 1'b1;
            else if (state != ST_STOP)                   stop_hw <= 1'b0;
        end
    end

    // per-state outputs
    always_comb begin
        int_mask  = ccr_imask;
        bus_grant = 1'b0;
        cpu_halt  = 1'b0;
        unique case (state)
            ST_RESET: begin
                int_mask = 1'b1;
                cpu_halt = 1'b1;
            end
            ST_EXCEPT: int_mask = 1'b1;
            ST_EXEC:   ;
            ST_BUSREL: begin
                bus_grant = 1'b1;
                cpu_halt  = 1'b1;
            end
            ST_STOP:   cpu_halt = 1'b1;
            default: begin
                int_mask = 1'b1;
                cpu_halt = 1'b1;
            end
        endcase
    end

    assign state_o = state;
endmodule

// File: rtl/pst_checker.sv
module pst_checker (
    input logic       clk,
    input logic       rst_pin_n,
    input logic       wdt_ovf,
    input logic [2:0] state_o,
    input logic       int_mask,
    input logic       vec_stb,
    input logic       bus_grant,
    input logic       cpu_halt,
    input logic       br_load
);
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_pin_n)
        state_o <= 3'd4); // R1
    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (state_o == 3'd0) |-> (int_mask && cpu_halt && !bus_grant)); // R3
    AST_WDT_TO_RESET: assert property (@(posedge clk) disable iff (!rst_pin_n)
        wdt_ovf |=> (state_o == 3'd0)); // R5
    AST_STB_TWO_CYC: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $rose(vec_stb) |=> vec_stb); // R7
    AST_LOAD_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (br_load && !wdt_ovf) |=> (state_o == 3'd2)); // R7
    AST_GRANT_HALTS: assert property (@(posedge clk) disable iff (!rst_pin_n)
        bus_grant |-> cpu_halt); // R8
    AST_NO_GRANT_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (vec_stb || br_load) |-> !bus_grant); // R9
endmodule

bind proc_state_ctrl pst_checker u_chk (
    .clk       (clk),
    .rst_pin_n (rst_pin_n),
    .wdt_ovf   (wdt_ovf),
    .state_o   (state_o),
    .int_mask  (int_mask),
    .vec_stb   (vec_stb),
    .bus_grant (bus_grant),
    .cpu_halt  (cpu_halt),
    .br_load   (br_load)
);

// File: tb/sim_proc_state_ctrl.sv
`timescale 1ns/1ps
module sim_proc_state_ctrl;
    localparam int VW = 8;
    localparam logic [2:0] S_RST = 3'd0, S_EXC = 3'd1, S_EXE = 3'd2,
                           S_BUS = 3'd3, S_STP = 3'd4;

    logic clk = 1'b0;
    logic rst_pin_n = 1'b0, wdt_ovf = 1'b0, exc_req = 1'b0;
    logic [VW-1:0] exc_vec = '0;
    logic bus_req = 1'b0, insn_bnd = 1'b0, sleep_exec = 1'b0;
    logic hw_standby = 1'b0, irq_wake = 1'b0, ccr_imask = 1'b1;
    logic [2:0] state_o;
    logic int_mask, vec_stb, bus_grant, cpu_halt, br_load;
    logic [VW+1:0] vec_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    proc_state_ctrl #(.VEC_W(VW), .STB_CYC(2)) u0 (
        .clk(clk), .rst_pin_n(rst_pin_n), .wdt_ovf(wdt_ovf), .exc_req(exc_req),
        .exc_vec(exc_vec), .bus_req(bus_req), .insn_bnd(insn_bnd),
        .sleep_exec(sleep_exec), .hw_standby(hw_standby), .irq_wake(irq_wake),
        .ccr_imask(ccr_imask), .state_o(state_o), .int_mask(int_mask),
        .vec_addr(vec_addr), .vec_stb(vec_stb), .bus_grant(bus_grant),
        .cpu_halt(cpu_halt), .br_load(br_load)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // checks the three-cycle exception sequence; first sample already taken in EXCEPT
    task automatic exc_seq(input string tag, input int addr);
        chk({tag, " R7 state"}, state_o, S_EXC);
        chk({tag, " R7 stb1"}, vec_stb, 1);
        chk({tag, " R7 addr"}, vec_addr, addr);
        chk({tag, " R3 mask in EXCEPT"}, int_mask, 1);
        step(1);
        chk({tag, " R7 stb2"}, vec_stb, 1);
        chk({tag, " R7 no load yet"}, br_load, 0);
        step(1);
        chk({tag, " R7 stb off"}, vec_stb, 0);
        chk({tag, " R7 load"}, br_load, 1);
        step(1);
        chk({tag, " R7 exec"}, state_o, S_EXE);
        chk({tag, " R7 load off"}, br_load, 0);
    endtask

    task automatic do_reset();
        rst_pin_n = 1'b0;
        step(2);
        rst_pin_n = 1'b1;
        step(6);
    endtask

    task automatic t_reset_exit();
        rst_pin_n = 1'b0;
        step(2);
        chk("R1 R2 reset code", state_o, S_RST);
        chk("R3 reset mask", int_mask, 1);
        chk("R3 reset halt", cpu_halt, 1);
        chk("R2 no grant", bus_grant, 0);
        rst_pin_n = 1'b1;
        step(2);
        chk("R4 still reset after 2 edges", state_o, S_RST);
        step(1);
        exc_seq("R4 reset vector", 0);
        ccr_imask = 1'b0;
        #1 chk("R3 mask follows ccr in EXEC", int_mask, 0);
        ccr_imask = 1'b1;
        #1 chk("R3 mask follows ccr set", int_mask, 1);
    endtask

    task automatic t_exception();
        exc_req = 1'b1; exc_vec = 8'h2A;
        step(1);
        exc_req = 1'b0; exc_vec = 8'h00;
        exc_seq("R6 trap", 8'h2A * 4);
    endtask

    task automatic t_bus();
        bus_req = 1'b1; insn_bnd = 1'b0;
        step(2);
        chk("R9 no boundary no grant", bus_grant, 0);
        chk("R9 stays exec", state_o, S_EXE);
        insn_bnd = 1'b1;
        step(1);
        insn_bnd = 1'b0;
        chk("R8 busrel", state_o, S_BUS);
        chk("R8 grant", bus_grant, 1);
        chk("R8 halt", cpu_halt, 1);
        step(2);
        chk("R8 held while requested", bus_grant, 1);
        bus_req = 1'b0;
        step(1);
        chk("R8 back to exec", state_o, S_EXE);
        chk("R8 grant released", bus_grant, 0);
    endtask

    task automatic t_bus_in_fetch();
        exc_req = 1'b1; exc_vec = 8'h05; bus_req = 1'b1; insn_bnd = 1'b1;
        step(1);
        exc_req = 1'b0;
        chk("R13 exc over bus", state_o, S_EXC);
        for (int i = 0; i < 3; i++) begin
            chk("R9 no grant in EXCEPT", bus_grant, 0);
            step(1);
        end
        chk("R9 exec after fetch", state_o, S_EXE);
        step(1);
        chk("R8 grant after fetch", bus_grant, 1);
        bus_req = 1'b0; insn_bnd = 1'b0;
        step(1);
    endtask

    task automatic t_sleep();
        sleep_exec = 1'b1;
        step(1);
        sleep_exec = 1'b0;
        chk("R10 stop", state_o, S_STP);
        chk("R10 halt", cpu_halt, 1);
        ccr_imask = 1'b1; irq_wake = 1'b1; exc_vec = 8'h11;
        step(2);
        chk("R11 masked wake ignored", state_o, S_STP);
        ccr_imask = 1'b0;
        step(1);
        irq_wake = 1'b0; exc_vec = 8'h00;
        exc_seq("R11 wake", 8'h11 * 4);
        chk("R3 mask follows ccr after wake", int_mask, 0);
        ccr_imask = 1'b1;
    endtask

    task automatic t_standby();
        hw_standby = 1'b1; exc_req = 1'b1; exc_vec = 8'h07;
        step(1);
        hw_standby = 1'b0; exc_req = 1'b0;
        chk("R13 standby over exc", state_o, S_STP);
        chk("R10 standby halt", cpu_halt, 1);
        ccr_imask = 1'b0; irq_wake = 1'b1;
        step(4);
        chk("R12 wake ignored in standby", state_o, S_STP);
        chk("R12 no strobe", vec_stb, 0);
        irq_wake = 1'b0; ccr_imask = 1'b1;
        do_reset();
        chk("R12 reset exits standby", state_o, S_EXE);
    endtask

    task automatic t_sleep_then_standby();
        sleep_exec = 1'b1;
        step(1);
        sleep_exec = 1'b0;
        hw_standby = 1'b1;
        step(1);
        hw_standby = 1'b0; ccr_imask = 1'b0; irq_wake = 1'b1;
        step(3);
        chk("R12 standby during sleep sticks", state_o, S_STP);
        irq_wake = 1'b0; ccr_imask = 1'b1;
        do_reset();
    endtask

    task automatic t_wdt();
        wdt_ovf = 1'b1;
        step(1);
        wdt_ovf = 1'b0;
        chk("R5 wdt reset", state_o, S_RST);
        chk("R5 wdt mask", int_mask, 1);
        step(1);
        exc_seq("R5 wdt vector", 0);
    endtask

    task automatic t_async_reset();
        bus_req = 1'b1; insn_bnd = 1'b1;
        step(1);
        insn_bnd = 1'b0;
        chk("R8 busrel before reset", state_o, S_BUS);
        #2 rst_pin_n = 1'b0;
        #1 chk("R2 async reset", state_o, S_RST);
        chk("R2 grant dropped", bus_grant, 0);
        bus_req = 1'b0;
        step(1);
        rst_pin_n = 1'b1;
        step(6);
        chk("R4 recovered", state_o, S_EXE);
    endtask

    initial begin
        step(1);
        t_reset_exit();
        t_exception();
        t_bus();
        t_bus_in_fetch();
        t_sleep();
        t_standby();
        t_sleep_then_standby();
        t_wdt();
        t_async_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule